// File: doc/BRIEF.md
# Readout card host register block

This block is the host-side control and status port of a processor readout card. A host addresses it through a 5-bit register address with separate read and write strobes. Writes drive the card's control lines: the processor reset, the enables of the event and histogram FIFO paths, the offline mode flag, the configuration pin of the input logic and two general-purpose lines toward the processor. Writes also pass single words on to the serial transmitter, the configuration byte stream and the dual-port RAM.

Reads return a 32-bit status word. This word combines the histogram FIFO count and flags, the event FIFO flags (inverted from their active-low pins), three processor output pins, two configuration status pins and an 8-bit event counter. The counter counts events that the processor has written and the reader has not yet consumed. It goes up on each rising edge of the processor's DMA-done strobe and down on each end-of-event pulse. Its non-zero state drives an event-ready output.

Words arriving from the processor's serial port land in a single holding register. That register carries a ready flag, and an overflow flag that is set when a new word replaces an unread one. Writes to the RAM data address go out at an internal address register, which then steps forward by one.

Top module: `host_reg_block`

## Requirements
- R1: After reset, proc_rst_no is low and remains low until the host writes bit 0 of the control register (address 0) as 1. All other control outputs, the event counter, event_rdy_o, the serial ready/overflow flags and all strobes are 0.
- R2: A write to address 0 loads bits 6:0 of the write data and ignores the higher bits. The bit mapping is: bit 0 proc_rst_no, bit 1 evt_fifo_en_o, bit 2 hist_fifo_en_o, bit 3 offline_o, bit 4 cfg_pin_o, bits 5 and 6 gp_o[0] and gp_o[1]. A read of address 0 returns those 7 bits, zero-extended.
- R3: A read of address 6 returns the status word. Its fields are: bits 8:0 hist_wc_i, bit 9 hist_full_i, bit 10 hist_empty_i, bit 11 the inverse of evt_ff_ni, bit 12 the inverse of evt_paf_ni, bit 13 the inverse of evt_ef_ni, bit 14 serial ready, bit 15 serial overflow, bits 23:16 event counter, bits 26:24 proc_pins_i[2:0], bits 29:27 zero, bits 31:30 cfg_stat_i[1:0].
- R4: The event counter rises by one at the clock edge that first samples dma_done_i high after it was low; holding dma_done_i high adds nothing more. It falls by one at each clock edge that samples evt_end_i high. When both happen in the same cycle, the count is unchanged.
- R5: The event counter saturates: an increment at 255 and a decrement at 0 leave it unchanged.
- R6: evt_rdy_o is high exactly when the event counter is non-zero.
- R7: A serial word strobed by ser_rx_vld_i is held and sets status bit 14. A read of address 8 returns the held word and clears bits 14 and 15. A new word that arrives in the same cycle as that read becomes the next ready word, and no overflow is flagged.
- R8: A serial word that arrives while the previous one is unread replaces it and sets status bit 15.
- R9: A write to address 2 loads the low RAM_AW bits of the data into the RAM address register. In the cycle after each write to address 3, ram_we_o is high for one cycle, with ram_addr_o equal to the address register and ram_data_o equal to the written data. The address register then steps by one and wraps from all-ones to zero.
- R10: In the cycle after a write to address 9, evt_fifo_rst_o is high for one cycle and the event counter reads 0. This clear overrides any increment or decrement in the same cycle.
- R11: In the cycle after a write to address 1, ser_tx_vld_o is high for one cycle with ser_tx_data_o equal to the write data. In the cycle after a write to address 4, cfg_vld_o is high for one cycle with cfg_byte_o equal to write data bits 7:0.
- R12: While rd_i is high with address 7, rdata_o returns hist_data_i zero-extended and hist_rd_o is high. A read of an unassigned or write-only address returns 0 and leaves hist_rd_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 5 | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational while rd_i is high |
| proc_rst_no | output | 1 | Processor reset, active low |
| evt_fifo_en_o | output | 1 | Event FIFO path enable |
| hist_fifo_en_o | output | 1 | Histogram FIFO path enable |
| offline_o | output | 1 | Offline mode flag |
| cfg_pin_o | output | 1 | Configuration pin of the input logic |
| gp_o | output | 2 | General-purpose lines to the processor |
| evt_fifo_rst_o | output | 1 | One-cycle event FIFO reset pulse |
| ser_tx_data_o | output | 32 | Word for the serial transmitter |
| ser_tx_vld_o | output | 1 | Serial transmit word valid |
| cfg_byte_o | output | 8 | Configuration byte |
| cfg_vld_o | output | 1 | Configuration byte valid |
| ram_addr_o | output | RAM_AW | RAM write address |
| ram_data_o | output | 32 | RAM write data |
| ram_we_o | output | 1 | RAM write enable |
| hist_rd_o | output | 1 | Histogram FIFO pop |
| hist_data_i | input | 8 | Histogram FIFO read data |
| hist_wc_i | input | 9 | Histogram FIFO word count |
| hist_full_i | input | 1 | Histogram FIFO full |
| hist_empty_i | input | 1 | Histogram FIFO empty |
| evt_ff_ni | input | 1 | Event FIFO full, active low |
| evt_paf_ni | input | 1 | Event FIFO almost full, active low |
| evt_ef_ni | input | 1 | Event FIFO empty, active low |
| ser_rx_data_i | input | 32 | Received serial word |
| ser_rx_vld_i | input | 1 | Received serial word valid |
| dma_done_i | input | 1 | Processor DMA event-written strobe |
| evt_end_i | input | 1 | End-of-event pulse from the reader |
| evt_rdy_o | output | 1 | Event counter non-zero |
| proc_pins_i | input | 3 | Processor output pin states |
| cfg_stat_i | input | 2 | Configuration status pins |

## Verification
The hardest states to reach are the counter limits and the same-cycle collisions. To reach them, the stimulus drives 260 DMA edges up from zero and 260 end pulses back down, reading the count after every step, so both saturation points are crossed. Separate sequences then produce each collision: a DMA edge and an end pulse together, a software clear together with a DMA edge, and a new serial word arriving while the held word is being read. Each of these is set up at a negative edge so that the stimulus lands on a single rising edge.

// File: rtl/host_reg_pkg.sv
package host_reg_pkg;
  localparam logic [4:0] A_CTRL     = 5'd0;
  localparam logic [4:0] A_SER_TX   = 5'd1;
  localparam logic [4:0] A_RAM_ADDR = 5'd2;
  localparam logic [4:0] A_RAM_DATA = 5'd3;
  localparam logic [4:0] A_CFG      = 5'd4;
  localparam logic [4:0] A_STATUS   = 5'd6;
  localparam logic [4:0] A_HIST     = 5'd7;
  localparam logic [4:0] A_SER_RX   = 5'd8;
  localparam logic [4:0] A_SW_RST   = 5'd9;

  localparam int EVT_CNT_W = 8;  // fixed by status bits 23:16
  localparam int HWC_W     = 9;  // fixed by status bits 8:0
  localparam int CTRL_W    = 7;

  // packed: first member is the MSB, so proc_run lands on bit 0
  typedef struct packed {
    logic gp1;
    logic gp0;
    logic cfg_pin;
    logic offline;
    logic hist_en;
    logic evt_en;
    logic proc_run;
  } ctrl_t;
endpackage

// File: rtl/evt_tally.sv
module evt_tally #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dma_done_i,
  input  logic             evt_end_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             rise_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             dma_q;
  logic [CNT_W-1:0] cnt_q;

  assign rise_o = dma_done_i & ~dma_q;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dma_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      dma_q <= dma_done_i;
      if (clr_i) begin
        cnt_q <= '0;
      end else begin
        unique case ({rise_o, evt_end_i})
          2'b10:   if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
          2'b01:   if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
          default: cnt_q <= cnt_q;
        endcase
      end
    end
  end
endmodule

// File: rtl/rx_mailbox.sv
module rx_mailbox #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] data_i,
  input  logic          vld_i,
  input  logic          take_i,
  output logic [DW-1:0] word_o,
  output logic          rdy_o,
  output logic          ovf_o
);
  logic [DW-1:0] word_q;
  logic          rdy_q, ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      rdy_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (vld_i) word_q <= data_i;
      if (take_i) begin
        // old word consumed; a same-cycle arrival is the next fresh word
        rdy_q <= vld_i;
        ovf_q <= 1'b0;
      end else if (vld_i) begin
        rdy_q <= 1'b1;
        ovf_q <= ovf_q | rdy_q;
      end
    end
  end

  assign word_o = word_q;
  assign rdy_o  = rdy_q;
  assign ovf_o  = ovf_q;
endmodule

// File: rtl/ram_ptr_gen.sv
module ram_ptr_gen #(
  parameter int AW = 15,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [AW-1:0] ptr_o,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [DW-1:0] wdata_o
);
  logic [AW-1:0] ptr_q, waddr_q;
  logic [DW-1:0] wd_q;
  logic          we_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      waddr_q <= '0;
      wd_q    <= '0;
      we_q    <= 1'b0;
    end else begin
      we_q <= wr_i;
      if (ld_i) begin
        ptr_q <= wdata_i[AW-1:0];
      end else if (wr_i) begin
        waddr_q <= ptr_q;
        wd_q    <= wdata_i;
        ptr_q   <= ptr_q + 1'b1;
      end
    end
  end

  assign ptr_o   = ptr_q;
  assign we_o    = we_q;
  assign waddr_o = waddr_q;
  assign wdata_o = wd_q;
endmodule

// File: rtl/host_reg_block.sv
module host_reg_block
  import host_reg_pkg::*;
#(
  parameter int RAM_AW = 15,
  parameter int DW     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [4:0]        addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              proc_rst_no,
  output logic              evt_fifo_en_o,
  output logic              hist_fifo_en_o,
  output logic              offline_o,
  output logic              cfg_pin_o,
  output logic [1:0]        gp_o,
  output logic              evt_fifo_rst_o,
  output logic [DW-1:0]     ser_tx_data_o,
  output logic              ser_tx_vld_o,
  output logic [7:0]        cfg_byte_o,
  output logic              cfg_vld_o,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic [DW-1:0]     ram_data_o,
  output logic              ram_we_o,
  output logic              hist_rd_o,
  input  logic [7:0]        hist_data_i,
  input  logic [HWC_W-1:0]  hist_wc_i,
  input  logic              hist_full_i,
  input  logic              hist_empty_i,
  input  logic              evt_ff_ni,
  input  logic              evt_paf_ni,
  input  logic              evt_ef_ni,
  input  logic [DW-1:0]     ser_rx_data_i,
  input  logic              ser_rx_vld_i,
  input  logic              dma_done_i,
  input  logic              evt_end_i,
  output logic              evt_rdy_o,
  input  logic [2:0]        proc_pins_i,
  input  logic [1:0]        cfg_stat_i
);
  logic wr_ctrl, wr_tx, wr_ram_a, wr_ram_d, wr_cfg, wr_swr, rd_rx;

  assign wr_ctrl  = wr_i && (addr_i == A_CTRL);
  assign wr_tx    = wr_i && (addr_i == A_SER_TX);
  assign wr_ram_a = wr_i && (addr_i == A_RAM_ADDR);
  assign wr_ram_d = wr_i && (addr_i == A_RAM_DATA);
  assign wr_cfg   = wr_i && (addr_i == A_CFG);
  assign wr_swr   = wr_i && (addr_i == A_SW_RST);
  assign rd_rx    = rd_i && (addr_i == A_SER_RX);

  ctrl_t         ctrl_q;
  logic          tx_vld_q, cfg_vld_q, swr_q;
  logic [DW-1:0] tx_data_q;
  logic [7:0]    cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      tx_vld_q  <= 1'b0;
      cfg_vld_q <= 1'b0;
      swr_q     <= 1'b0;
      tx_data_q <= '0;
      cfg_q     <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      tx_vld_q  <= wr_tx;
      cfg_vld_q <= wr_cfg;
      swr_q     <= wr_swr;
      if (wr_tx)  tx_data_q <= wdata_i;
      if (wr_cfg) cfg_q     <= wdata_i[7:0];
    end
  end

  logic [EVT_CNT_W-1:0] evt_cnt;
  logic                 dma_rise;

  evt_tally #(.CNT_W(EVT_CNT_W)) u_tally (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dma_done_i (dma_done_i),
    .evt_end_i  (evt_end_i),
    .clr_i      (wr_swr),
    .cnt_o      (evt_cnt),
    .rise_o     (dma_rise)
  );

  logic [DW-1:0] rx_word;
  logic          ser_rdy, ser_ovf;

  rx_mailbox #(.DW(DW)) u_mbox (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .data_i (ser_rx_data_i),
    .vld_i  (ser_rx_vld_i),
    .take_i (rd_rx),
    .word_o (rx_word),
    .rdy_o  (ser_rdy),
    .ovf_o  (ser_ovf)
  );

  logic [RAM_AW-1:0] ram_ptr;

  ram_ptr_gen #(.AW(RAM_AW), .DW(DW)) u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ld_i    (wr_ram_a),
    .wr_i    (wr_ram_d),
    .wdata_i (wdata_i),
    .ptr_o   (ram_ptr),
    .we_o    (ram_we_o),
    .waddr_o (ram_addr_o),
    .wdata_o (ram_data_o)
  );

  logic [31:0] status;
  assign status = {cfg_stat_i, 3'b000, proc_pins_i, evt_cnt, ser_ovf, ser_rdy,
                   ~evt_ef_ni, ~evt_paf_ni, ~evt_ff_ni, hist_empty_i, hist_full_i,
                   hist_wc_i};

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (addr_i)
        A_CTRL:   rdata_o = DW'(ctrl_q);
        A_STATUS: rdata_o = DW'(status);
        A_HIST:   rdata_o = DW'(hist_data_i);
        A_SER_RX: rdata_o = rx_word;
        default:  rdata_o = '0;
      endcase
    end
  end

  assign hist_rd_o      = rd_i && (addr_i == A_HIST);
  assign proc_rst_no    = ctrl_q.proc_run;
  assign evt_fifo_en_o  = ctrl_q.evt_en;
  assign hist_fifo_en_o = ctrl_q.hist_en;
  assign offline_o      = ctrl_q.offline;
  assign cfg_pin_o      = ctrl_q.cfg_pin;
  assign gp_o           = {ctrl_q.gp1, ctrl_q.gp0};
  assign evt_fifo_rst_o = swr_q;
  assign ser_tx_data_o  = tx_data_q;
  assign ser_tx_vld_o   = tx_vld_q;
  assign cfg_byte_o     = cfg_q;
  assign cfg_vld_o      = cfg_vld_q;
  assign evt_rdy_o      = |evt_cnt;
endmodule

// File: rtl/host_reg_chk.sv
module host_reg_chk #(
  parameter int RAM_AW = 15
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [4:0]        addr_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic              ser_rx_vld_i,
  input logic              evt_end_i,
  input logic [7:0]        evt_cnt,
  input logic              dma_rise,
  input logic              ser_rdy,
  input logic              ser_ovf,
  input logic [RAM_AW-1:0] ram_ptr,
  input logic              ram_we_o,
  input logic [RAM_AW-1:0] ram_addr_o,
  input logic              evt_fifo_rst_o,
  input logic              proc_rst_no,
  input logic              evt_rdy_o
);
  logic swr, rx_take;
  assign swr     = wr_i && (addr_i == 5'd9);
  assign rx_take = rd_i && (addr_i == 5'd8);

  assert_rst_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!proc_rst_no && !(wr_i && addr_i == 5'd0)) |=> !proc_rst_no);

  assert_both_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_rise && evt_end_i && !swr) |=> $stable(evt_cnt));

  assert_sat_top_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_cnt == 8'hFF && !evt_end_i && !swr) |=> (evt_cnt == 8'hFF));

  assert_idle_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_cnt == 8'd0 && !dma_rise) |=> !evt_rdy_o);

  assert_take_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_take && !ser_rx_vld_i) |=> (!ser_rdy && !ser_ovf));

  assert_overwrite_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_rx_vld_i && ser_rdy && !rx_take) |=> ser_ovf);

  assert_ptr_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 5'd3) |=>
      (ram_we_o && ram_addr_o == $past(ram_ptr) &&
       ram_ptr == RAM_AW'($past(ram_ptr) + 1'b1)));

  assert_soft_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swr |=> (evt_fifo_rst_o && evt_cnt == 8'd0));
endmodule

bind host_reg_block host_reg_chk #(.RAM_AW(RAM_AW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .addr_i         (addr_i),
  .wr_i           (wr_i),
  .rd_i           (rd_i),
  .ser_rx_vld_i   (ser_rx_vld_i),
  .evt_end_i      (evt_end_i),
  .evt_cnt        (evt_cnt),
  .dma_rise       (dma_rise),
  .ser_rdy        (ser_rdy),
  .ser_ovf        (ser_ovf),
  .ram_ptr        (ram_ptr),
  .ram_we_o       (ram_we_o),
  .ram_addr_o     (ram_addr_o),
  .evt_fifo_rst_o (evt_fifo_rst_o),
  .proc_rst_no    (proc_rst_no),
  .evt_rdy_o      (evt_rdy_o)
);

// File: tb/host_reg_block_tb_top.sv
module host_reg_block_tb_top;
  localparam int AW = 15;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic [4:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        proc_rst_n, evt_en, hist_en, offline, cfg_pin;
  logic [1:0]  gp;
  logic        evt_rst, tx_vld, cfg_vld, ram_we, hist_rd, evt_rdy;
  logic [31:0] tx_data, ram_data;
  logic [7:0]  cfg_byte;
  logic [AW-1:0] ram_addr;
  logic [7:0]  hist_data = '0;
  logic [8:0]  hist_wc = '0;
  logic        hist_full = 1'b0, hist_empty = 1'b0;
  logic        ff_n = 1'b1, paf_n = 1'b1, ef_n = 1'b1;
  logic [31:0] rx_data = '0;
  logic        rx_vld = 1'b0, dma = 1'b0, evt_end = 1'b0;
  logic [2:0]  pins = '0;
  logic [1:0]  cstat = '0;

  host_reg_block #(.RAM_AW(AW), .DW(32)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .proc_rst_no(proc_rst_n),
    .evt_fifo_en_o(evt_en), .hist_fifo_en_o(hist_en), .offline_o(offline),
    .cfg_pin_o(cfg_pin), .gp_o(gp), .evt_fifo_rst_o(evt_rst),
    .ser_tx_data_o(tx_data), .ser_tx_vld_o(tx_vld), .cfg_byte_o(cfg_byte),
    .cfg_vld_o(cfg_vld), .ram_addr_o(ram_addr), .ram_data_o(ram_data),
    .ram_we_o(ram_we), .hist_rd_o(hist_rd), .hist_data_i(hist_data),
    .hist_wc_i(hist_wc), .hist_full_i(hist_full), .hist_empty_i(hist_empty),
    .evt_ff_ni(ff_n), .evt_paf_ni(paf_n), .evt_ef_ni(ef_n),
    .ser_rx_data_i(rx_data), .ser_rx_vld_i(rx_vld), .dma_done_i(dma),
    .evt_end_i(evt_end), .evt_rdy_o(evt_rdy), .proc_pins_i(pins),
    .cfg_stat_i(cstat)
  );

  int checks = 0;
  int failures = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(posedge clk);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic pulse_dma();
    @(negedge clk); dma = 1'b1;
    @(negedge clk); dma = 1'b0;
  endtask

  task automatic pulse_end();
    @(negedge clk); evt_end = 1'b1;
    @(negedge clk); evt_end = 1'b0;
  endtask

  task automatic push_rx(input logic [31:0] d);
    @(negedge clk); rx_data = d; rx_vld = 1'b1;
    @(negedge clk); rx_vld = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic [31:0] exp;
    int cnt;

    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 ctrl outputs", {24'd0, gp, cfg_pin, offline, hist_en, evt_en, proc_rst_n}, 32'd0);
    check("R1 strobes", {evt_rst, tx_vld, cfg_vld, ram_we, evt_rdy}, 32'd0);
    rd_reg(5'd6, v);
    check("R1 status", v, 32'd0);
    repeat (5) @(negedge clk);
    check("R1 reset held", {31'd0, proc_rst_n}, 32'd0);

    // R2: control sweep with garbage in upper bits
    for (int i = 0; i < 128; i++) begin
      wr_reg(5'd0, 32'hA5A5_A500 ^ (32'(i) | 32'hFFFF_FF80));
      check("R2 ctrl pins", {25'd0, gp, cfg_pin, offline, hist_en, evt_en, proc_rst_n}, 32'(i));
      rd_reg(5'd0, v);
      check("R2 ctrl readback", v, 32'(i));
    end

    // R3: status layout sweep
    for (int i = 0; i < 512; i++) begin
      @(negedge clk);
      hist_wc = 9'(i);
      hist_full = i[0]; hist_empty = i[3];
      ff_n = i[1]; paf_n = i[4]; ef_n = i[6];
      pins = 3'(i >> 2); cstat = 2'(i >> 5);
      exp = {2'(i >> 5), 3'b000, 3'(i >> 2), 8'd0, 2'b00, ~i[6], ~i[4], ~i[1],
             i[3], i[0], 9'(i)};
      rd_reg(5'd6, v);
      check("R3 status", v, exp);
    end
    @(negedge clk);
    hist_wc = '0; hist_full = 0; hist_empty = 0; ff_n = 1; paf_n = 1; ef_n = 1;
    pins = '0; cstat = '0;

    // R4/R5/R6: count up through saturation
    for (int k = 1; k <= 260; k++) begin
      pulse_dma();
      cnt = (k > 255) ? 255 : k;
      rd_reg(5'd6, v);
      check("R4 R5 count up", {24'd0, v[23:16]}, 32'(cnt));
      check("R6 ready up", {31'd0, evt_rdy}, 32'(cnt != 0));
    end
    for (int k = 1; k <= 260; k++) begin
      pulse_end();
      cnt = (255 - k < 0) ? 0 : 255 - k;
      rd_reg(5'd6, v);
      check("R4 R5 count down", {24'd0, v[23:16]}, 32'(cnt));
      check("R6 ready down", {31'd0, evt_rdy}, 32'(cnt != 0));
    end

    // R4: held high counts once
    @(negedge clk); dma = 1'b1;
    repeat (5) @(negedge clk);
    dma = 1'b0;
    rd_reg(5'd6, v);
    check("R4 held high", {24'd0, v[23:16]}, 32'd1);
    // R4: simultaneous edge and end
    @(negedge clk); dma = 1'b1; evt_end = 1'b1;
    @(negedge clk); dma = 1'b0; evt_end = 1'b0;
    rd_reg(5'd6, v);
    check("R4 simultaneous", {24'd0, v[23:16]}, 32'd1);
    pulse_end();
    check("R6 back to idle", {31'd0, evt_rdy}, 32'd0);

    // R10: software clear against a same-cycle DMA edge
    pulse_dma(); pulse_dma(); pulse_dma();
    rd_reg(5'd6, v);
    check("R10 pre count", {24'd0, v[23:16]}, 32'd3);
    @(negedge clk); addr = 5'd9; wr = 1'b1; dma = 1'b1;
    @(negedge clk); wr = 1'b0; dma = 1'b0;
    check("R10 fifo reset pulse", {31'd0, evt_rst}, 32'd1);
    check("R10 ready cleared", {31'd0, evt_rdy}, 32'd0);
    @(negedge clk);
    check("R10 pulse ends", {31'd0, evt_rst}, 32'd0);
    rd_reg(5'd6, v);
    check("R10 count cleared", {24'd0, v[23:16]}, 32'd0);

    // R7: single word
    push_rx(32'hCAFE_0001);
    rd_reg(5'd6, v);
    check("R7 ready flag", {30'd0, v[15:14]}, 32'd1);
    rd_reg(5'd8, v);
    check("R7 word", v, 32'hCAFE_0001);
    rd_reg(5'd6, v);
    check("R7 flags cleared", {30'd0, v[15:14]}, 32'd0);
    // R8: overwrite keeps newest
    push_rx(32'h1111_2222);
    push_rx(32'h3333_4444);
    rd_reg(5'd6, v);
    check("R8 overflow flag", {30'd0, v[15:14]}, 32'd3);
    rd_reg(5'd8, v);
    check("R8 newest kept", v, 32'h3333_4444);
    rd_reg(5'd6, v);
    check("R8 flags cleared", {30'd0, v[15:14]}, 32'd0);
    // R7: arrival during read
    push_rx(32'h0000_00AA);
    @(negedge clk); addr = 5'd8; rd = 1'b1; rx_data = 32'h0000_00BB; rx_vld = 1'b1;
    #1 v = rdata;
    check("R7 read during arrival", v, 32'h0000_00AA);
    @(negedge clk); rd = 1'b0; rx_vld = 1'b0;
    rd_reg(5'd6, v);
    check("R7 next ready no ovf", {30'd0, v[15:14]}, 32'd1);
    rd_reg(5'd8, v);
    check("R7 next word", v, 32'h0000_00BB);

    // R9: RAM address load, step and wrap
    wr_reg(5'd2, 32'hABCD_7FFE);
    for (int k = 0; k < 3; k++) begin
      wr_reg(5'd3, 32'h5000_0000 + 32'(k));
      check("R9 we", {31'd0, ram_we}, 32'd1);
      check("R9 addr wrap", 32'(ram_addr), 32'((32'h7FFE + k) & 32'h7FFF));
      check("R9 data", ram_data, 32'h5000_0000 + 32'(k));
      @(negedge clk);
      check("R9 we one cycle", {31'd0, ram_we}, 32'd0);
    end
    wr_reg(5'd2, 32'h0000_0100);
    for (int k = 0; k < 40; k++) begin
      wr_reg(5'd3, 32'(k * 7));
      check("R9 addr sweep", 32'(ram_addr), 32'h100 + 32'(k));
    end

    // R11: transmit word and configuration byte
    wr_reg(5'd1, 32'hDEAD_BEEF);
    check("R11 tx valid", {31'd0, tx_vld}, 32'd1);
    check("R11 tx data", tx_data, 32'hDEAD_BEEF);
    @(negedge clk);
    check("R11 tx one cycle", {31'd0, tx_vld}, 32'd0);
    wr_reg(5'd4, 32'h0123_45AB);
    check("R11 cfg valid", {31'd0, cfg_vld}, 32'd1);
    check("R11 cfg byte", {24'd0, cfg_byte}, 32'h0000_00AB);
    @(negedge clk);
    check("R11 cfg one cycle", {31'd0, cfg_vld}, 32'd0);

    // R12: histogram read and dead addresses
    @(negedge clk); hist_data = 8'h5C; addr = 5'd7; rd = 1'b1;
    #1;
    check("R12 hist data", rdata, 32'h0000_005C);
    check("R12 hist pop", {31'd0, hist_rd}, 32'd1);
    @(negedge clk); rd = 1'b0;
    foreach (v[i]) if (i < 32 && (i == 1 || i == 2 || i == 3 || i == 4 || i == 5 ||
                                  i == 9 || i == 17 || i == 31)) begin
      @(negedge clk); addr = 5'(i); rd = 1'b1;
      #1;
      check("R12 dead address reads zero", rdata, 32'd0);
      check("R12 no pop", {31'd0, hist_rd}, 32'd0);
      @(negedge clk); rd = 1'b0;
    end

    finish_run();
  end
endmodule